// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block chooses the low-power state a microcontroller enters when its CPU issues a stop or wait request, and it brings the device back out of that state. Two power-down select bits pick a stop depth: Stop1, Stop2 or the lightest, Stop3. The controller then demotes a deep request to Stop3 whenever on-chip debug or in-stop low-voltage detection must keep running. The same keep-alive settings hold the debug clock on and keep the regulator out of standby for the length of the stop.

Wake sources arrive asynchronously and pass through a two-flop synchronizer. These sources are the reset pin, a set of interrupt lines, the real-time-interrupt tick, a low-voltage event and a debug wake command. A small arbiter picks one source per cycle by a fixed priority. The controller then returns to run mode with exactly one result: a reset request, an interrupt-vector request with its index, or entry into active debug. A registered status path rejects debug memory accesses with an error while the device is not running.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After reset, `mode` is RUN (0), the CPU and peripheral clocks are enabled and the regulator is not in standby. A `stop_req` seen in RUN moves `mode`, on the next clock edge, to STOP3 (4) if `pd_en`=0, to STOP2 (3) if `pd_en`=1 and `pd_partial`=1, and to STOP1 (2) if `pd_en`=1 and `pd_partial`=0. Without `stop_req`, a `wait_req` moves it to WAIT (1).
- R2: If `dbg_en` is 1 when the stop request is accepted, a Stop1 or Stop2 selection enters STOP3 instead.
- R3: If both `lv_en` and `lv_stop_en` are 1 when the stop request is accepted, a Stop1 or Stop2 selection enters STOP3 instead. `lv_en` alone does not alter the depth.
- R4: In a stop entered with `dbg_en`=1, `dbg_clk_en`=1 and `reg_standby`=0. In a stop entered with neither keep-alive condition, `reg_standby`=1 and `dbg_clk_en`=0.
- R5: In a stop entered with low-voltage detection kept alive, `reg_standby`=0 for the whole stop.
- R6: `slow_osc_en` is 1 one cycle after `rti_sel` is nonzero and 0 one cycle after it is zero. With `rti_sel`=0, `rti_tick` never wakes the device.
- R7: With the slow source enabled, `rti_tick` wakes from STOP2 or STOP3 with `vec_req`=1 and `vec_id`=NIRQ. In STOP1 it has no effect.
- R8: `rst_pin` wakes from WAIT or any stop. It gives `mode`=RUN, a one-cycle `reset_req` pulse and `vec_req`=0.
- R9: `irq[i]` wakes from WAIT, STOP2 or STOP3 with a one-cycle `vec_req` pulse, and `vec_id` is the lowest active line index.
- R10: `dbg_wake_cmd` in a stop entered with `dbg_en`=1 returns to RUN with `dbg_active`=1 and no vector or reset. In any other stop it is ignored.
- R11: A `dbg_mem_req` issued while `mode` is not RUN gives `dbg_mem_err`=1 and `dbg_mem_ok`=0 on the next cycle. In RUN it gives `dbg_mem_ok`=1 and `dbg_mem_err`=0.
- R12: A `lv_event` in a stop with low-voltage detection kept alive wakes the device. It gives `reset_req` if `lv_rst_sel`=1, or else `vec_req` with `vec_id`=NIRQ+1.
- R13: Each wake input is acted on at the third clock edge after it rises, because it passes two synchronizer flops. When `rst_pin` and interrupts are active together, the reset wins and no vector is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | CPU stop request (synchronous) |
| wait_req | input | 1 | CPU wait request (synchronous) |
| pd_en | input | 1 | Power-down select: deep stop enabled |
| pd_partial | input | 1 | Power-down select: partial (Stop2) vs full (Stop1) |
| dbg_en | input | 1 | Debug kept alive in stop |
| lv_en | input | 1 | Low-voltage detect enable |
| lv_stop_en | input | 1 | Low-voltage detect active in stop |
| lv_rst_sel | input | 1 | Low-voltage event causes reset (1) or interrupt (0) |
| rti_sel | input | 3 | Real-time-interrupt rate select, 0 disables |
| irq | input | NIRQ | Asynchronous interrupt lines |
| rti_tick | input | 1 | Real-time-interrupt event |
| rst_pin | input | 1 | External reset pin |
| lv_event | input | 1 | Low-voltage event |
| dbg_wake_cmd | input | 1 | Debug wake command |
| dbg_mem_req | input | 1 | Debug memory access with status |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_standby | output | 1 | Regulator standby request |
| slow_osc_en | output | 1 | Slow wake oscillator enable |
| reset_req | output | 1 | One-cycle full reset request |
| vec_req | output | 1 | One-cycle interrupt-vector request |
| vec_id | output | VW | Vector index, valid with vec_req |
| dbg_active | output | 1 | Woken into active debug |
| dbg_mem_ok | output | 1 | Debug access performed |
| dbg_mem_err | output | 1 | Debug access refused, not running |

## Verification
The bench drives each stop selection with the keep-alive bits set in turn. A controller that ignored either demotion rule would be caught sitting in Stop1 or Stop2 with debug or voltage monitoring starved. It also checks that the regulator is kept out of standby in that case. The bench fires wake sources in modes that must ignore them: a real-time tick in Stop1 or with the source off, and a debug wake without debug kept alive. A wrong eligibility table would show up as a spurious return to run. It drives reset and interrupts together, and several interrupts at once, which would expose a vector issued alongside a reset or the wrong line index. It samples exactly at the third edge, which catches a missing or extra synchronizer stage.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_WAIT  = 3'd1,
    M_STOP1 = 3'd2,
    M_STOP2 = 3'd3,
    M_STOP3 = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_RESET  = 2'd1,
    WK_VECTOR = 2'd2,
    WK_DEBUG  = 2'd3
  } wake_e;

  function automatic logic is_stop(input mode_e m);
    return (m == M_STOP1) || (m == M_STOP2) || (m == M_STOP3);
  endfunction

endpackage

// File: rtl/stopctl_sync.sv
module stopctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/stopctl_resolve.sv
module stopctl_resolve
  import stopctl_pkg::*;
(
  input  logic  pd_en,
  input  logic  pd_partial,
  input  logic  dbg_en,
  input  logic  lv_en,
  input  logic  lv_stop_en,
  output mode_e target,
  output logic  keep_dbg,
  output logic  keep_lv
);

  mode_e asked;

  always_comb begin
    if (!pd_en)          asked = M_STOP3;
    else if (pd_partial) asked = M_STOP2;
    else                 asked = M_STOP1;
  end

  assign keep_dbg = dbg_en;
  assign keep_lv  = lv_en & lv_stop_en;

  // Deep stop would cut power that debug or voltage monitoring needs.
  assign target = (keep_dbg || keep_lv) ? M_STOP3 : asked;

endmodule

// File: rtl/stopctl_wake_arb.sv
module stopctl_wake_arb
  import stopctl_pkg::*;
#(
  parameter int NIRQ = 4,
  localparam int VW  = $clog2(NIRQ + 2)
) (
  input  mode_e            mode,
  input  logic             keep_dbg,
  input  logic             keep_lv,
  input  logic             rti_on,
  input  logic             lv_rst_sel,
  input  logic             pin_s,
  input  logic             lv_s,
  input  logic             dbg_s,
  input  logic             rti_s,
  input  logic [NIRQ-1:0]  irq_s,
  output wake_e            kind,
  output logic [VW-1:0]    vec
);

  localparam logic [VW-1:0] VEC_RTI = VW'(NIRQ);
  localparam logic [VW-1:0] VEC_LV  = VW'(NIRQ + 1);

  logic [NIRQ-1:0] first;
  logic [VW-1:0]   irq_idx;
  logic            pin_ok, irq_ok, rti_ok, lv_ok, dbg_ok;

  for (genvar i = 0; i < NIRQ; i++) begin : g_first
    if (i == 0) begin : g_lo
      assign first[i] = irq_s[0];
    end else begin : g_hi
      assign first[i] = irq_s[i] & ~(|irq_s[i-1:0]);
    end
  end

  always_comb begin
    irq_idx = '0;
    for (int i = 0; i < NIRQ; i++)
      if (first[i]) irq_idx = VW'(i);
  end

  assign pin_ok = (mode != M_RUN);
  assign irq_ok = (mode == M_WAIT) || (mode == M_STOP2) || (mode == M_STOP3);
  assign rti_ok = irq_ok && rti_on;
  assign lv_ok  = (mode == M_STOP3) && keep_lv;
  assign dbg_ok = (mode == M_STOP3) && keep_dbg;

  always_comb begin
    kind = WK_NONE;
    vec  = '0;
    if (pin_ok && pin_s) begin
      kind = WK_RESET;
    end else if (lv_ok && lv_s) begin
      if (lv_rst_sel) kind = WK_RESET;
      else begin
        kind = WK_VECTOR;
        vec  = VEC_LV;
      end
    end else if (dbg_ok && dbg_s) begin
      kind = WK_DEBUG;
    end else if (irq_ok && |irq_s) begin
      kind = WK_VECTOR;
      vec  = irq_idx;
    end else if (rti_ok && rti_s) begin
      kind = WK_VECTOR;
      vec  = VEC_RTI;
    end
  end

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import stopctl_pkg::*;
#(
  parameter int NIRQ      = 4,
  parameter int SYNC_STG  = 2,
  localparam int VW       = $clog2(NIRQ + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stop_req,
  input  logic            wait_req,
  input  logic            pd_en,
  input  logic            pd_partial,
  input  logic            dbg_en,
  input  logic            lv_en,
  input  logic            lv_stop_en,
  input  logic            lv_rst_sel,
  input  logic [2:0]      rti_sel,
  input  logic [NIRQ-1:0] irq,
  input  logic            rti_tick,
  input  logic            rst_pin,
  input  logic            lv_event,
  input  logic            dbg_wake_cmd,
  input  logic            dbg_mem_req,
  output logic [2:0]      mode,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            dbg_clk_en,
  output logic            reg_standby,
  output logic            slow_osc_en,
  output logic            reset_req,
  output logic            vec_req,
  output logic [VW-1:0]   vec_id,
  output logic            dbg_active,
  output logic            dbg_mem_ok,
  output logic            dbg_mem_err
);

  localparam int SW = NIRQ + 4;

  // Synchronized wake inputs
  logic [SW-1:0]   async_in, sync_out;
  logic [NIRQ-1:0] irq_s;
  logic            pin_s, lv_s, dbg_s, rti_s;

  assign async_in = {dbg_wake_cmd, lv_event, rst_pin, rti_tick, irq};

  stopctl_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (sync_out)
  );

  assign irq_s = sync_out[NIRQ-1:0];
  assign rti_s = sync_out[NIRQ];
  assign pin_s = sync_out[NIRQ+1];
  assign lv_s  = sync_out[NIRQ+2];
  assign dbg_s = sync_out[NIRQ+3];

  // Depth resolution
  mode_e target;
  logic  res_keep_dbg, res_keep_lv;

  stopctl_resolve u_res (
    .pd_en      (pd_en),
    .pd_partial (pd_partial),
    .dbg_en     (dbg_en),
    .lv_en      (lv_en),
    .lv_stop_en (lv_stop_en),
    .target     (target),
    .keep_dbg   (res_keep_dbg),
    .keep_lv    (res_keep_lv)
  );

  // State
  mode_e          mode_q, mode_d;
  logic           keep_dbg_q, keep_dbg_d, keep_lv_q, keep_lv_d;
  logic           dbg_act_d;
  wake_e          kind;
  logic [VW-1:0]  arb_vec;

  stopctl_wake_arb #(.NIRQ(NIRQ)) u_arb (
    .mode       (mode_q),
    .keep_dbg   (keep_dbg_q),
    .keep_lv    (keep_lv_q),
    .rti_on     (slow_osc_en),
    .lv_rst_sel (lv_rst_sel),
    .pin_s      (pin_s),
    .lv_s       (lv_s),
    .dbg_s      (dbg_s),
    .rti_s      (rti_s),
    .irq_s      (irq_s),
    .kind       (kind),
    .vec        (arb_vec)
  );

  logic          rst_req_d, vec_req_d;
  logic [VW-1:0] vec_id_d;

  always_comb begin
    mode_d     = mode_q;
    keep_dbg_d = keep_dbg_q;
    keep_lv_d  = keep_lv_q;
    dbg_act_d  = dbg_active;
    rst_req_d  = 1'b0;
    vec_req_d  = 1'b0;
    vec_id_d   = '0;
    if (mode_q == M_RUN) begin
      if (stop_req) begin
        mode_d     = target;
        keep_dbg_d = res_keep_dbg;
        keep_lv_d  = res_keep_lv;
        dbg_act_d  = 1'b0;
      end else if (wait_req) begin
        mode_d    = M_WAIT;
        dbg_act_d = 1'b0;
      end
    end else if (kind != WK_NONE) begin
      mode_d     = M_RUN;
      keep_dbg_d = 1'b0;
      keep_lv_d  = 1'b0;
      case (kind)
        WK_RESET:  rst_req_d = 1'b1;
        WK_DEBUG:  dbg_act_d = 1'b1;
        WK_VECTOR: begin
          vec_req_d = 1'b1;
          vec_id_d  = arb_vec;
        end
        default: ;
      endcase
    end
  end

  // Registered outputs, aligned with the mode they describe
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= M_RUN;
      keep_dbg_q    <= 1'b0;
      keep_lv_q     <= 1'b0;
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= 1'b1;
      dbg_clk_en    <= 1'b1;
      reg_standby   <= 1'b0;
      slow_osc_en   <= 1'b0;
      reset_req     <= 1'b0;
      vec_req       <= 1'b0;
      vec_id        <= '0;
      dbg_active    <= 1'b0;
      dbg_mem_ok    <= 1'b0;
      dbg_mem_err   <= 1'b0;
    end else begin
      mode_q        <= mode_d;
      keep_dbg_q    <= keep_dbg_d;
      keep_lv_q     <= keep_lv_d;
      cpu_clk_en    <= (mode_d == M_RUN);
      periph_clk_en <= (mode_d == M_RUN) || (mode_d == M_WAIT);
      dbg_clk_en    <= (mode_d == M_RUN) || (mode_d == M_WAIT) || keep_dbg_d;
      reg_standby   <= is_stop(mode_d) && !keep_dbg_d && !keep_lv_d;
      slow_osc_en   <= (rti_sel != 3'd0);
      reset_req     <= rst_req_d;
      vec_req       <= vec_req_d;
      vec_id        <= vec_id_d;
      dbg_active    <= dbg_act_d;
      dbg_mem_ok    <= dbg_mem_req && (mode_q == M_RUN);
      dbg_mem_err   <= dbg_mem_req && (mode_q != M_RUN);
    end
  end

  assign mode = mode_q;

  // Assertions
  p_stop_entry_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RUN && stop_req) |=> is_stop(mode_q));

  p_dbg_light_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RUN && stop_req && dbg_en) |=> (mode_q == M_STOP3));

  p_lv_light_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RUN && stop_req && lv_en && lv_stop_en) |=> (mode_q == M_STOP3));

  p_dbg_alive_r4: assert property (@(posedge clk) disable iff (rst)
    (is_stop(mode_q) && keep_dbg_q) |-> (dbg_clk_en && !reg_standby));

  p_lv_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (is_stop(mode_q) && keep_lv_q) |-> !reg_standby);

  p_rti_off_r6: assert property (@(posedge clk) disable iff (rst)
    (rti_sel == 3'd0) |=> !slow_osc_en);

  p_stop1_novec_r7: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> ($past(mode_q) != M_STOP1));

  p_one_exit_r8: assert property (@(posedge clk) disable iff (rst)
    !(reset_req && vec_req));

  p_mem_err_r11: assert property (@(posedge clk) disable iff (rst)
    (dbg_mem_req && mode_q != M_RUN) |=> (dbg_mem_err && !dbg_mem_ok));

endmodule

// File: tb/sim_stop_mode_ctrl.sv
module sim_stop_mode_ctrl;

  localparam int CLK_P = 10;
  localparam int NIRQ  = 4;
  localparam int VW    = $clog2(NIRQ + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, wait_req = 0, pd_en = 0, pd_partial = 0;
  logic dbg_en = 0, lv_en = 0, lv_stop_en = 0, lv_rst_sel = 0;
  logic [2:0] rti_sel = 3'd0;
  logic [NIRQ-1:0] irq = '0;
  logic rti_tick = 0, rst_pin = 0, lv_event = 0, dbg_wake_cmd = 0, dbg_mem_req = 0;
  logic [2:0] mode;
  logic cpu_clk_en, periph_clk_en, dbg_clk_en, reg_standby, slow_osc_en;
  logic reset_req, vec_req, dbg_active, dbg_mem_ok, dbg_mem_err;
  logic [VW-1:0] vec_id;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  stop_mode_ctrl #(.NIRQ(NIRQ)) u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
    .pd_en(pd_en), .pd_partial(pd_partial), .dbg_en(dbg_en),
    .lv_en(lv_en), .lv_stop_en(lv_stop_en), .lv_rst_sel(lv_rst_sel),
    .rti_sel(rti_sel), .irq(irq), .rti_tick(rti_tick), .rst_pin(rst_pin),
    .lv_event(lv_event), .dbg_wake_cmd(dbg_wake_cmd), .dbg_mem_req(dbg_mem_req),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .dbg_clk_en(dbg_clk_en), .reg_standby(reg_standby), .slow_osc_en(slow_osc_en),
    .reset_req(reset_req), .vec_req(vec_req), .vec_id(vec_id),
    .dbg_active(dbg_active), .dbg_mem_ok(dbg_mem_ok), .dbg_mem_err(dbg_mem_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic enter_stop(input logic pe, input logic pp);
    pd_en = pe; pd_partial = pp; stop_req = 1'b1;
    step(1);
    stop_req = 1'b0;
  endtask

  task automatic pin_exit(input string req);
    rst_pin = 1'b1;
    step(3);
    chk(req, "reset_req on pin", reset_req, 1);
    chk(req, "mode after pin", mode, 0);
    chk(req, "vec_req on pin", vec_req, 0);
    step(1);
    chk(req, "reset_req pulse ends", reset_req, 0);
    rst_pin = 1'b0;
    step(3);
  endtask

  task automatic t_reset;
    chk("R1", "reset mode", mode, 0);
    chk("R1", "reset cpu clk", cpu_clk_en, 1);
    chk("R1", "reset periph clk", periph_clk_en, 1);
    chk("R1", "reset standby", reg_standby, 0);
    chk("R1", "reset vec_req", vec_req, 0);
  endtask

  task automatic t_depths;
    enter_stop(1'b1, 1'b0);
    chk("R1", "stop1 code", mode, 2);
    chk("R4", "stop1 standby", reg_standby, 1);
    chk("R1", "stop1 cpu clk", cpu_clk_en, 0);
    pin_exit("R8");
    enter_stop(1'b1, 1'b1);
    chk("R1", "stop2 code", mode, 3);
    pin_exit("R8");
    enter_stop(1'b0, 1'b1);
    chk("R1", "stop3 code", mode, 4);
    pin_exit("R8");
    wait_req = 1'b1; step(1); wait_req = 1'b0;
    chk("R1", "wait code", mode, 1);
    chk("R1", "wait periph clk", periph_clk_en, 1);
    pin_exit("R8");
  endtask

  task automatic t_debug;
    dbg_en = 1'b1;
    enter_stop(1'b1, 1'b0);
    chk("R2", "stop1 demoted", mode, 4);
    chk("R4", "dbg clk kept", dbg_clk_en, 1);
    chk("R4", "regulator active", reg_standby, 0);
    dbg_wake_cmd = 1'b1;
    step(2);
    chk("R13", "no wake before third edge", mode, 4);
    step(1);
    chk("R10", "dbg wake mode", mode, 0);
    chk("R10", "dbg_active", dbg_active, 1);
    chk("R10", "no vector", vec_req, 0);
    chk("R10", "no reset", reset_req, 0);
    dbg_wake_cmd = 1'b0; step(3);
    dbg_en = 1'b0;
    enter_stop(1'b1, 1'b1);
    chk("R2", "stop2 without dbg", mode, 3);
    pin_exit("R8");
    enter_stop(1'b0, 1'b0);
    chk("R4", "dbg clk off", dbg_clk_en, 0);
    chk("R4", "standby on", reg_standby, 1);
    dbg_wake_cmd = 1'b1; step(4);
    chk("R10", "dbg cmd ignored", mode, 4);
    chk("R10", "dbg_active stays 0", dbg_active, 0);
    dbg_wake_cmd = 1'b0; step(3);
    pin_exit("R8");
  endtask

  task automatic t_lv;
    lv_en = 1'b1; lv_stop_en = 1'b0;
    enter_stop(1'b1, 1'b1);
    chk("R3", "lv_en alone keeps stop2", mode, 3);
    pin_exit("R8");
    lv_stop_en = 1'b1;
    enter_stop(1'b1, 1'b0);
    chk("R3", "lv demotes stop1", mode, 4);
    chk("R5", "regulator active", reg_standby, 0);
    step(5);
    chk("R5", "regulator still active", reg_standby, 0);
    lv_rst_sel = 1'b0; lv_event = 1'b1;
    step(3);
    chk("R12", "lv irq vec_req", vec_req, 1);
    chk("R12", "lv irq vec_id", vec_id, NIRQ + 1);
    chk("R12", "lv irq mode", mode, 0);
    lv_event = 1'b0; step(3);
    enter_stop(1'b1, 1'b1);
    lv_rst_sel = 1'b1; lv_event = 1'b1;
    step(3);
    chk("R12", "lv reset", reset_req, 1);
    chk("R12", "lv reset no vec", vec_req, 0);
    lv_event = 1'b0; step(3);
    lv_en = 1'b0; lv_stop_en = 1'b0; lv_rst_sel = 1'b0;
  endtask

  task automatic t_rti;
    rti_sel = 3'd0; step(1);
    chk("R6", "slow osc off", slow_osc_en, 0);
    enter_stop(1'b1, 1'b1);
    rti_tick = 1'b1; step(4);
    chk("R6", "tick ignored when off", mode, 3);
    rti_tick = 1'b0; step(3);
    rti_sel = 3'd2; step(1);
    chk("R6", "slow osc on", slow_osc_en, 1);
    rti_tick = 1'b1; step(3);
    chk("R7", "rti wake mode", mode, 0);
    chk("R7", "rti vec_req", vec_req, 1);
    chk("R7", "rti vec_id", vec_id, NIRQ);
    step(1);
    chk("R7", "vec_req pulse ends", vec_req, 0);
    rti_tick = 1'b0; step(3);
    enter_stop(1'b1, 1'b0);
    rti_tick = 1'b1; step(4);
    chk("R7", "stop1 ignores rti", mode, 2);
    chk("R7", "stop1 no vec", vec_req, 0);
    rti_tick = 1'b0; step(3);
    pin_exit("R8");
    rti_sel = 3'd0;
  endtask

  task automatic t_irq;
    enter_stop(1'b1, 1'b1);
    irq = 4'b0110; step(3);
    chk("R9", "irq wake mode", mode, 0);
    chk("R9", "irq vec_req", vec_req, 1);
    chk("R9", "lowest line wins", vec_id, 1);
    irq = '0; step(3);
    wait_req = 1'b1; step(1); wait_req = 1'b0;
    irq = 4'b1100; step(3);
    chk("R9", "wait irq vec_id", vec_id, 2);
    irq = '0; step(3);
    enter_stop(1'b1, 1'b0);
    irq = 4'b0001; step(4);
    chk("R9", "stop1 ignores irq", mode, 2);
    irq = '0; step(3);
    pin_exit("R8");
    enter_stop(1'b0, 1'b0);
    irq = 4'b1000; rst_pin = 1'b1; step(3);
    chk("R13", "reset wins", reset_req, 1);
    chk("R13", "no vector with reset", vec_req, 0);
    irq = '0; rst_pin = 1'b0; step(3);
  endtask

  task automatic t_mem;
    dbg_mem_req = 1'b1; step(1); dbg_mem_req = 1'b0;
    chk("R11", "run ok", dbg_mem_ok, 1);
    chk("R11", "run no err", dbg_mem_err, 0);
    enter_stop(1'b0, 1'b0);
    dbg_mem_req = 1'b1; step(1); dbg_mem_req = 1'b0;
    chk("R11", "stop err", dbg_mem_err, 1);
    chk("R11", "stop not ok", dbg_mem_ok, 0);
    pin_exit("R8");
    wait_req = 1'b1; step(1); wait_req = 1'b0;
    dbg_mem_req = 1'b1; step(1); dbg_mem_req = 1'b0;
    chk("R11", "wait err", dbg_mem_err, 1);
    pin_exit("R8");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_depths();
    t_debug();
    t_lv();
    t_rti();
    t_irq();
    t_mem();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule